// File: doc/BRIEF.md
# Speculative Address-Bus Arbiter with Priority I/O Port

This block decides which of nine nodes drives the shared address bus in each bus cycle. Eight ordinary nodes have one request line each. The ninth node, an I/O port, has two request lines. Its urgent line lets it cap the latency of its reads. Its ordinary line lets it take part in the normal rotation like any other node. The arbiter samples all request lines at every clock edge. It registers a one-hot grant that lasts exactly one cycle, and that cycle is the winner's address slot.

A node may request before it knows it needs the bus. If it wins and has nothing to send, it keeps `cmd_real` low during its slot, and the slot becomes a no-op. The arbiter raises `cmd_issued` for one cycle after each slot that carried a real command. Sequence counters further down the chip advance on that pulse only, so a cancelled slot never consumes a sequence number.

Top module: `addr_arb`

## Requirements
- R1: While `rst` is high, `gnt` and `cmd_issued` are all zero on the next cycle. After reset, the rotation starts at node 0, so the first normal grant goes to the lowest-numbered node that is requesting.
- R2: At most one bit of `gnt` is set in any cycle. Bit i of `gnt` is node i, and bit 8 is the I/O node.
- R3: If no request line is high at a clock edge, `gnt` is zero during the following cycle.
- R4: A grant appears in the cycle after the edge at which the request was sampled. It goes only to a node that was requesting at that edge.
- R5: Normal requests are served in round-robin order. Ordinary node i sits at position i, and the I/O node's low line sits at position 8. The search starts one position after the last normal winner and wraps from 8 to 0.
- R6: When `req_io_hi` is high at an edge, the next cycle grants bit 8, ahead of every normal request. A grant won this way leaves the round-robin position unchanged.
- R7: When `cmd_real` is high during a granted cycle, `cmd_issued` is high for the following cycle.
- R8: When `cmd_real` is low during a granted cycle (a no-op slot), `cmd_issued` stays low in the following cycle.
- R9: `cmd_real` has no effect in a cycle with no grant. `cmd_issued` stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_norm | input | 8 | Request line of each ordinary node |
| req_io_hi | input | 1 | Urgent request from the I/O node |
| req_io_lo | input | 1 | Ordinary request from the I/O node |
| cmd_real | input | 1 | Winner sends a real command in its slot (low = no-op) |
| gnt | output | 9 | One-hot grant for the current slot |
| cmd_issued | output | 1 | One-cycle pulse after a slot that carried a real command |

## Verification
Several properties are checked on every cycle: the grant is never more than one-hot, it goes only to a node that requested, it is empty when nothing was requested, the urgent line always takes the next slot, and `cmd_issued` follows exactly the slots that were granted and real. The round-robin order cannot be checked that way, because it depends on where the pointer stood after earlier winners. The bench's scenarios show it instead: the wrap from position 8 to 0, the pointer holding still across urgent grants, and the pointer returning to node 0 after a reset in the middle of a run.

// File: rtl/addr_arb_pkg.sv
package addr_arb_pkg;

    // What kind of slot the registered grant represents
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_PRIO = 2'd1,
        SLOT_RR   = 2'd2
    } slot_kind_e;

    localparam int DEF_NORM_NODES = 8;

    // Position after idx in a ring of n entries
    function automatic int ring_next(input int idx, input int n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 9,
    parameter int PW = 4
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] start,
    output logic          found,
    output logic [PW-1:0] win_idx
);
    localparam int SW = PW + 1;

    logic [SW-1:0] cand;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        cand    = '0;
        for (int k = 0; k < N; k++) begin
            cand = {1'b0, start} + SW'(k);
            if (cand >= SW'(N)) cand = cand - SW'(N);
            if (!found && req[cand[PW-1:0]]) begin
                found   = 1'b1;
                win_idx = cand[PW-1:0];
            end
        end
    end

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
    import addr_arb_pkg::*;
#(
    parameter int N  = 9,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prio_req,
    input  logic          rr_found,
    input  logic [PW-1:0] rr_idx,
    output logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output slot_kind_e    kind
);
    logic [PW-1:0] ptr_step;

    always_comb begin
        ptr_step = PW'(ring_next(int'(rr_idx), N));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt  <= '0;
            ptr  <= '0;
            kind <= SLOT_IDLE;
        end else if (prio_req) begin
            gnt        <= '0;
            gnt[N-1]   <= 1'b1;
            kind       <= SLOT_PRIO;
        end else if (rr_found) begin
            gnt         <= '0;
            gnt[rr_idx] <= 1'b1;
            ptr         <= ptr_step;
            kind        <= SLOT_RR;
        end else begin
            gnt  <= '0;
            kind <= SLOT_IDLE;
        end
    end

endmodule

// File: rtl/arb_cmd_track.sv
module arb_cmd_track
    import addr_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_kind_e kind,
    input  logic       cmd_real,
    output logic       cmd_issued
);
    logic slot_live;

    always_comb begin
        slot_live = (kind != SLOT_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_issued <= 1'b0;
        else     cmd_issued <= slot_live && cmd_real;
    end

endmodule

// File: rtl/addr_arb.sv
module addr_arb
    import addr_arb_pkg::*;
#(
    parameter int N_NORM = DEF_NORM_NODES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_NORM-1:0] req_norm,
    input  logic              req_io_hi,
    input  logic              req_io_lo,
    input  logic              cmd_real,
    output logic [N_NORM:0]   gnt,
    output logic              cmd_issued
);
    localparam int NODES = N_NORM + 1;
    localparam int PW    = $clog2(NODES);

    logic [NODES-1:0] rr_req;
    logic [PW-1:0]    ptr;
    logic             rr_found;
    logic [PW-1:0]    rr_idx;
    slot_kind_e       kind;

    always_comb begin
        rr_req = {req_io_lo, req_norm};
    end

    arb_rr_pick #(.N(NODES), .PW(PW)) u_pick (
        .req     (rr_req),
        .start   (ptr),
        .found   (rr_found),
        .win_idx (rr_idx)
    );

    arb_grant_reg #(.N(NODES), .PW(PW)) u_grant (
        .clk      (clk),
        .rst      (rst),
        .prio_req (req_io_hi),
        .rr_found (rr_found),
        .rr_idx   (rr_idx),
        .ptr      (ptr),
        .gnt      (gnt),
        .kind     (kind)
    );

    arb_cmd_track u_track (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .cmd_real   (cmd_real),
        .cmd_issued (cmd_issued)
    );

endmodule

// File: rtl/addr_arb_chk.sv
module addr_arb_chk #(
    parameter int N_NORM = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_NORM-1:0] req_norm,
    input logic              req_io_hi,
    input logic              req_io_lo,
    input logic              cmd_real,
    input logic [N_NORM:0]   gnt,
    input logic              cmd_issued
);
    logic [N_NORM:0] any_req;
    always_comb any_req = {req_io_hi | req_io_lo, req_norm};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (gnt == '0 && !cmd_issued));

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R3
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (any_req == '0) |=> (gnt == '0));

    // R4
    grant_requested_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((gnt & ~$past(any_req)) == '0));

    // R6
    prio_wins_chk: assert property (@(posedge clk) disable iff (rst)
        req_io_hi |=> gnt[N_NORM]);

    // R7
    real_issue_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt != '0) && cmd_real) |=> cmd_issued);

    // R8
    noop_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt != '0) && !cmd_real) |=> !cmd_issued);

    // R9
    no_slot_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt == '0) |=> !cmd_issued);

endmodule

bind addr_arb addr_arb_chk #(.N_NORM(N_NORM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_norm   (req_norm),
    .req_io_hi  (req_io_hi),
    .req_io_lo  (req_io_lo),
    .cmd_real   (cmd_real),
    .gnt        (gnt),
    .cmd_issued (cmd_issued)
);

// File: tb/test_addr_arb.sv
`timescale 1ns/1ps
module test_addr_arb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_norm = '0;
    logic       req_io_hi = 1'b0;
    logic       req_io_lo = 1'b0;
    logic       cmd_real = 1'b0;
    logic [8:0] gnt;
    logic       cmd_issued;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    addr_arb i_addr_arb (
        .clk        (clk),
        .rst        (rst),
        .req_norm   (req_norm),
        .req_io_hi  (req_io_hi),
        .req_io_lo  (req_io_lo),
        .cmd_real   (cmd_real),
        .gnt        (gnt),
        .cmd_issued (cmd_issued)
    );

    typedef struct packed {
        logic [7:0] norm;
        logic       hi;
        logic       lo;
        logic       rl;
        logic [8:0] egnt;
        logic       eiss;
    } vec_t;

    // cmd_real (rl) applies to the grant visible while the vector is driven,
    // i.e. the previous vector's expected grant.
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0}, // R3 nothing requested
        '{8'h05, 1'b0, 1'b0, 1'b1, 9'h001, 1'b0}, // R1 pointer at 0, R9
        '{8'h05, 1'b0, 1'b0, 1'b1, 9'h004, 1'b1}, // R5 next after 0, R7
        '{8'h05, 1'b0, 1'b0, 1'b0, 9'h001, 1'b0}, // R5 wrap, R8 no-op
        '{8'h80, 1'b0, 1'b1, 1'b1, 9'h080, 1'b1}, // R5 skip to 7
        '{8'h80, 1'b0, 1'b1, 1'b1, 9'h100, 1'b1}, // R5 I/O low at position 8
        '{8'h80, 1'b0, 1'b1, 1'b0, 9'h080, 1'b0}, // R5 wrap 8 to 0, R8
        '{8'hFF, 1'b1, 1'b0, 1'b1, 9'h100, 1'b1}, // R6 urgent beats all
        '{8'hFF, 1'b0, 1'b0, 1'b1, 9'h001, 1'b1}, // R6 pointer held at 8
        '{8'hFF, 1'b1, 1'b0, 1'b0, 9'h100, 1'b0}, // R6 again, R8
        '{8'h00, 1'b0, 1'b0, 1'b1, 9'h000, 1'b1}, // R3, R7
        '{8'h00, 1'b0, 1'b0, 1'b1, 9'h000, 1'b0}, // R9 real without slot
        '{8'h01, 1'b0, 1'b0, 1'b0, 9'h001, 1'b0}, // R4 lone requester
        '{8'h02, 1'b0, 1'b0, 1'b1, 9'h002, 1'b1}, // R4, R7
        '{8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0}  // R3
    };

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset grant", gnt, 9'h000);
        check("R1 reset issue", {8'h00, cmd_issued}, 9'h000);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            req_norm  = VEC[v].norm;
            req_io_hi = VEC[v].hi;
            req_io_lo = VEC[v].lo;
            cmd_real  = VEC[v].rl;
            tick();
            check("R5 grant", gnt, VEC[v].egnt);
            check("R7 issue", {8'h00, cmd_issued}, {8'h00, VEC[v].eiss});
            check("R2 onehot", {8'h00, ($countones(gnt) <= 1)}, 9'h001);
        end

        // R4: single requester, moves pointer to 4
        req_norm = 8'h08;
        cmd_real = 1'b0;
        tick();
        check("R4 node3", gnt, 9'h008);

        // R1: reset mid-run clears grant and issue
        rst      = 1'b1;
        req_norm = 8'h21;
        cmd_real = 1'b1;
        tick();
        check("R1 mid reset grant", gnt, 9'h000);
        check("R1 mid reset issue", {8'h00, cmd_issued}, 9'h000);

        // R1: pointer back to 0, so node 0 beats node 5
        rst      = 1'b0;
        cmd_real = 1'b0;
        tick();
        check("R1 pointer restart", gnt, 9'h001);

        req_norm = 8'h00;
        tick();
        check("R3 idle after", gnt, 9'h000);
        check("R8 no-op after", {8'h00, cmd_issued}, 9'h000);

        finish_run();
    end

endmodule